// File: doc/BRIEF.md
# Multi-Mode Local Timer Cell

A 16-bit timer cell built around one register and one equality comparator, both shared by four operating modes. In capture mode the cell latches the timer bus on selected edges of its input line. In compare mode it fires when the timer bus reaches a stored compare value. In timer mode it counts input ticks and fires on wrap-around. In reset-timer mode it counts ticks and is cleared by an event from the cell below it. Each event can raise a one-cycle service request and apply a set, clear or toggle action to the cell's output pin.

Cells are meant to be placed in a row. Each cell forwards the event line it receives from below to the cell above. A cell can also add its own events to that line. A compare cell watching a reset timer can therefore end the timer's period, and further compare cells stacked above can use the forwarded period event to drive their own pins. The result is a set of PWM channels that share one period and have independent duties. Compare values written by software are held back until the timer bus next reads zero, so a duty change never lands in the middle of a period. A one-shot option freezes the cell after its first event until the control word is written again.

Top module: `ltc_cell`

## Requirements
- R1: After reset, pin_o, srq_o and reg_o are zero, and chain_o is zero while chain_i is low.
- R2: In capture mode (mode 00), reg_o takes the value of tbus_i when the selected input condition occurs. The edge field selects the condition: 01 rising edge, 10 falling edge, 11 both edges, 00 while the input is high. Edges that are not selected leave reg_o unchanged and raise no request. The input passes through two synchronizer flops and a previous-sample flop, so a change at evt_i acts at the third following clock edge.
- R3: In compare mode (mode 01), reg_o shows the active compare value. An event occurs in the first cycle in which tbus_i equals that value.
- R4: A value written with cmp_wr_i becomes the active compare value at the clock edge that ends a cycle in which tbus_i is zero. Until then, the previous value stays in force.
- R5: In timer mode (mode 10), reg_o increments by one on each selected input condition. The step from all ones to zero is an event.
- R6: In reset-timer mode (mode 11), reg_o increments by one on each selected input condition. A high chain_i clears reg_o to zero at the next edge and counts as an event.
- R7: The pin action field is applied to pin_o at the clock edge of an event: 00 hold, 01 set, 10 clear, 11 toggle.
- R8: Each event produces srq_o high for exactly one cycle, in the cycle after the event's clock edge.
- R9: With one-shot set, the cell ignores all input conditions, compare matches and chain actions after its first event. reg_o and pin_o stay frozen until the next control write (cfg_we_i).
- R10: chain_o is high in any cycle in which chain_i is high. When link_own_i was set at the last control write, chain_o is also high in the cycle of the cell's own event.
- R11: In capture, compare and timer modes, a high chain_i applies the pin action to pin_o at the next edge without raising srq_o.
- R12: In a chain made of a period compare cell, a reset timer and duty compare cells using the toggle action, the reset timer's period is the period compare value plus one. Each duty pin is high for the period minus one minus its duty value in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control write strobe; latches the fields below and clears the one-shot lock |
| mode_i | input | 2 | 00 capture, 01 compare, 10 timer, 11 reset timer |
| edge_sel_i | input | 2 | Input condition: 00 high level, 01 rising, 10 falling, 11 both |
| pin_act_i | input | 2 | Pin action: 00 hold, 01 set, 10 clear, 11 toggle |
| one_shot_i | input | 1 | Freeze the cell after its first event |
| link_own_i | input | 1 | Add the cell's own events to chain_o |
| cmp_wr_i | input | 1 | Write strobe for the pending compare value |
| cmp_val_i | input | 16 | Compare value to write |
| evt_i | input | 1 | Selected input or clock-event line (asynchronous) |
| tbus_i | input | 16 | Timer value from the neighbouring reset timer |
| chain_i | input | 1 | Event or action line from the next lower cell |
| pin_o | output | 1 | Output pin |
| srq_o | output | 1 | Service request pulse |
| chain_o | output | 1 | Event or action line to the next higher cell |
| reg_o | output | 16 | Capture, count or active compare value |

## Verification
The single-pulse check on srq_o assumes that a cell's events never fall on two consecutive edges. The stimulus respects this by holding evt_i at each level for three cycles, by pulsing chain_i for one cycle with gaps, and by moving the timer bus only forward so each compare value is reached once. The timer-step and reset-clear properties are checked only in cycles without a control write, because such a write can change the mode at that same edge. The stimulus keeps control writes apart from input events.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  typedef enum logic [1:0] {
    MODE_CAP = 2'b00,
    MODE_CMP = 2'b01,
    MODE_TMR = 2'b10,
    MODE_RT  = 2'b11
  } ltc_mode_e;

  typedef enum logic [1:0] {
    ESEL_LVL  = 2'b00,
    ESEL_RISE = 2'b01,
    ESEL_FALL = 2'b10,
    ESEL_BOTH = 2'b11
  } ltc_esel_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } ltc_act_e;

  typedef struct packed {
    ltc_mode_e mode;
    ltc_esel_e esel;
    ltc_act_e  act;
    logic      one_shot;
    logic      link_own;
  } ltc_cfg_t;
endpackage

// File: rtl/ltc_edge_det.sv
module ltc_edge_det
  import ltc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sig_i,
  input  ltc_esel_e esel_i,
  output logic      hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= sig_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  always_comb begin
    unique case (esel_i)
      ESEL_LVL:  hit_o = cur;
      ESEL_RISE: hit_o = cur & ~prev_q;
      ESEL_FALL: hit_o = ~cur & prev_q;
      ESEL_BOTH: hit_o = cur ^ prev_q;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ltc_shadow.sv
module ltc_shadow #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] tbus_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] shd_q;
  logic [W-1:0] act_q;
  logic         pend_q;

  // a write always wins; a pending value waits for the bus to read zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else if (wr_i) begin
      shd_q  <= val_i;
      pend_q <= 1'b1;
    end else if (pend_q && (tbus_i == '0)) begin
      act_q  <= shd_q;
      pend_q <= 1'b0;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/ltc_pin.sv
module ltc_pin
  import ltc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ev_i,
  input  ltc_act_e act_i,
  output logic     pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (ev_i) begin
      unique case (act_i)
        ACT_SET:  pin_q <= 1'b1;
        ACT_CLR:  pin_q <= 1'b0;
        ACT_TGL:  pin_q <= ~pin_q;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/ltc_cell.sv
module ltc_cell
  import ltc_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [1:0]   mode_i,
  input  logic [1:0]   edge_sel_i,
  input  logic [1:0]   pin_act_i,
  input  logic         one_shot_i,
  input  logic         link_own_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_val_i,
  input  logic         evt_i,
  input  logic [W-1:0] tbus_i,
  input  logic         chain_i,
  output logic         pin_o,
  output logic         srq_o,
  output logic         chain_o,
  output logic [W-1:0] reg_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  ltc_cfg_t  cfg_q;
  ltc_mode_e mode_q;
  ltc_act_e  act_q;
  logic      lock_q;
  logic      eq_q;
  logic      srq_q;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] cmp_act;
  logic      tick;
  logic      eq;
  logic      own_ev;
  logic      pin_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{mode: MODE_CAP, esel: ESEL_RISE, act: ACT_HOLD,
                 one_shot: 1'b0, link_own: 1'b0};
    end else if (cfg_we_i) begin
      cfg_q <= '{mode: ltc_mode_e'(mode_i), esel: ltc_esel_e'(edge_sel_i),
                 act: ltc_act_e'(pin_act_i), one_shot: one_shot_i,
                 link_own: link_own_i};
    end
  end

  assign mode_q = cfg_q.mode;
  assign act_q  = cfg_q.act;

  ltc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (evt_i),
    .esel_i (cfg_q.esel),
    .hit_o  (tick)
  );

  ltc_shadow #(.W(W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cmp_wr_i),
    .val_i  (cmp_val_i),
    .tbus_i (tbus_i),
    .act_o  (cmp_act)
  );

  assign eq = (tbus_i == cmp_act);

  always_comb begin
    cnt_d  = cnt_q;
    own_ev = 1'b0;
    unique case (mode_q)
      MODE_CAP: begin
        if (tick) begin
          cnt_d  = tbus_i;
          own_ev = 1'b1;
        end
      end
      MODE_CMP: own_ev = eq & ~eq_q;
      MODE_TMR: begin
        if (tick) begin
          cnt_d  = cnt_q + 1'b1;
          own_ev = (cnt_q == CNT_MAX);
        end
      end
      MODE_RT: begin
        if (chain_i) begin
          cnt_d  = '0;
          own_ev = 1'b1;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (lock_q) begin
      cnt_d  = cnt_q;
      own_ev = 1'b0;
    end
  end

  // linked action from below acts on the pin in all modes but reset timer
  assign pin_ev  = own_ev | (chain_i & (mode_q != MODE_RT) & ~lock_q);
  assign chain_o = chain_i | (cfg_q.link_own & own_ev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      eq_q   <= 1'b0;
      srq_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      eq_q  <= eq;
      srq_q <= own_ev;
      if (cfg_we_i)                      lock_q <= 1'b0;
      else if (cfg_q.one_shot && own_ev) lock_q <= 1'b1;
    end
  end

  ltc_pin u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (pin_ev),
    .act_i  (act_q),
    .pin_o  (pin_o)
  );

  assign srq_o = srq_q;
  assign reg_o = (mode_q == MODE_CMP) ? cmp_act : cnt_q;
endmodule

// File: rtl/ltc_cell_chk.sv
module ltc_cell_chk
  import ltc_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cfg_we_i,
  input logic         chain_i,
  input logic         chain_o,
  input logic         srq_o,
  input logic         pin_o,
  input logic [W-1:0] reg_o,
  input ltc_mode_e    mode_q,
  input ltc_act_e     act_q,
  input logic         lock_q,
  input logic         tick,
  input logic         pin_ev
);
  AST_CHAIN_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_i |-> chain_o); // R10

  AST_SRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srq_o |=> !srq_o); // R8

  AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !cfg_we_i) |=> !srq_o); // R9

  AST_LOCK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !cfg_we_i) |=> ($stable(reg_o) && $stable(pin_o))); // R9

  AST_RT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RT && chain_i && !lock_q && !cfg_we_i) |=> (reg_o == '0)); // R6

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TMR && tick && !lock_q && !cfg_we_i)
      |=> (reg_o == W'($past(reg_o) + 1'b1))); // R5

  AST_PIN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_ev && act_q == ACT_SET) |=> pin_o); // R7

  AST_PIN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_ev && act_q == ACT_CLR) |=> !pin_o); // R7

  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_ev |=> $stable(pin_o)); // R7
endmodule

bind ltc_cell ltc_cell_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .chain_i  (chain_i),
  .chain_o  (chain_o),
  .srq_o    (srq_o),
  .pin_o    (pin_o),
  .reg_o    (reg_o),
  .mode_q   (mode_q),
  .act_q    (act_q),
  .lock_q   (lock_q),
  .tick     (tick),
  .pin_ev   (pin_ev)
);

// File: tb/sim_ltc_cell.sv
`timescale 1ns/1ps
module sim_ltc_cell;
  localparam int NPW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // single cell under test
  logic        cfg_we = 1'b0, os = 1'b0, link = 1'b0, cw = 1'b0, evt = 1'b0, chn = 1'b0;
  logic [1:0]  mode = 2'b00, esel = 2'b01, act = 2'b00;
  logic [15:0] cv = '0, tbus = '0;
  logic        pin, srq, chain_out;
  logic [15:0] regv;

  ltc_cell u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .mode_i(mode),
    .edge_sel_i(esel), .pin_act_i(act), .one_shot_i(os), .link_own_i(link),
    .cmp_wr_i(cw), .cmp_val_i(cv), .evt_i(evt), .tbus_i(tbus),
    .chain_i(chn), .pin_o(pin), .srq_o(srq), .chain_o(chain_out), .reg_o(regv)
  );

  // PWM chain: 0 period compare, 1 reset timer, 2..3 duty compares
  logic        pw_we = 1'b0, pw_evt = 1'b0;
  logic [1:0]  pw_mode [NPW];
  logic [1:0]  pw_act  [NPW];
  logic        pw_link [NPW];
  logic        pw_cw   [NPW];
  logic [15:0] pw_cv   [NPW];
  logic        pw_pin  [NPW];
  logic        pw_srq  [NPW];
  logic        pw_cho  [NPW];
  logic        pw_chi  [NPW];
  logic [15:0] pw_reg  [NPW];
  logic [15:0] pw_bus  [NPW];
  logic        pw_ein  [NPW];

  for (genvar i = 0; i < NPW; i++) begin : g_pwm
    if (i == 0) begin : g_lo
      assign pw_chi[i] = 1'b0;
    end else begin : g_up
      assign pw_chi[i] = pw_cho[i-1];
    end
    assign pw_bus[i] = (i == 1) ? 16'h0000 : pw_reg[1];
    assign pw_ein[i] = (i == 1) ? pw_evt : 1'b0;
    ltc_cell u_c (
      .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(pw_we), .mode_i(pw_mode[i]),
      .edge_sel_i(2'b00), .pin_act_i(pw_act[i]), .one_shot_i(1'b0),
      .link_own_i(pw_link[i]), .cmp_wr_i(pw_cw[i]), .cmp_val_i(pw_cv[i]),
      .evt_i(pw_ein[i]), .tbus_i(pw_bus[i]), .chain_i(pw_chi[i]),
      .pin_o(pw_pin[i]), .srq_o(pw_srq[i]), .chain_o(pw_cho[i]), .reg_o(pw_reg[i])
    );
  end

  // scoreboard
  typedef struct {
    logic [15:0] val;
    logic        pin;
    logic        chk_chain;
    string       req;
  } exp_t;
  exp_t sb_q[$];
  logic chain_prev = 1'b0;
  logic exp_pin    = 1'b0;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic chk16(string req, logic [15:0] a, logic [15:0] e);
    n_checks++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic chk1(string req, logic a, logic e);
    n_checks++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, a, e);
    end
  endtask

  function automatic logic pin_next(logic p, logic [1:0] a);
    case (a)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~p;
      default: return p;
    endcase
  endfunction

  task automatic expect_ev(logic [15:0] v, logic ch, string req);
    exp_t it;
    exp_pin      = pin_next(exp_pin, act);
    it.val       = v;
    it.pin       = exp_pin;
    it.chk_chain = ch;
    it.req       = req;
    sb_q.push_back(it);
  endtask

  // monitor: every srq pulse must match the oldest expected event
  always @(negedge clk_i) begin
    if (rst_ni && srq) begin
      if (sb_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R8 unexpected request actual=1 expected=0 reg=%h", regv);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        chk16({it.req, " event value"}, regv, it.val);
        chk1({it.req, " R7 pin after event"}, pin, it.pin);
        if (it.chk_chain) chk1("R10 own event on chain", chain_prev, 1'b1);
      end
    end
    chain_prev = chain_out;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic cfg(logic [1:0] m, logic [1:0] e, logic [1:0] a, logic o, logic l);
    mode = m; esel = e; act = a; os = o; link = l;
    cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
    step(1);
  endtask

  task automatic pulse();
    evt = 1'b1;
    step(3);
    evt = 1'b0;
    step(4);
  endtask

  task automatic sweep(int a, int b);
    for (int v = a; v <= b; v++) begin
      tbus = 16'(v);
      step(1);
    end
  endtask

  task automatic count_high(int idx, int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (pw_pin[idx]) hi++;
    end
  endtask

  initial begin
    for (int i = 0; i < NPW; i++) begin
      pw_mode[i] = 2'b00; pw_act[i] = 2'b00; pw_link[i] = 1'b0;
      pw_cw[i] = 1'b0; pw_cv[i] = '0;
    end
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] a;
    int hi;
    int npulse;
    step(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk1("R1 pin reset", pin, 1'b0);
    chk1("R1 srq reset", srq, 1'b0);
    chk16("R1 reg reset", regv, 16'h0000);
    chk1("R1 chain reset", chain_out, 1'b0);
    step(1);

    // capture, rising edge, set; falling edge ignored
    cfg(2'b00, 2'b01, 2'b01, 1'b0, 1'b0);
    tbus = 16'h1234;
    expect_ev(16'h1234, 1'b0, "R2 rising capture");
    pulse();
    tbus = 16'h5555;
    chk16("R2 falling edge ignored", regv, 16'h1234);

    // capture, falling edge, toggle
    cfg(2'b00, 2'b10, 2'b11, 1'b0, 1'b0);
    tbus = 16'h0042;
    expect_ev(16'h0042, 1'b0, "R2 falling capture");
    pulse();

    // capture, both edges, toggle
    cfg(2'b00, 2'b11, 2'b11, 1'b0, 1'b0);
    tbus = 16'h0777;
    expect_ev(16'h0777, 1'b0, "R2 both rise");
    evt = 1'b1;
    step(3);
    tbus = 16'h0888;
    expect_ev(16'h0888, 1'b0, "R2 both fall");
    evt = 1'b0;
    step(4);

    // compare with held-back update
    tbus = 16'h0000;
    cv = 16'h0010; cw = 1'b1;
    step(1);
    cw = 1'b0;
    step(2);
    cfg(2'b01, 2'b01, 2'b11, 1'b0, 1'b1);
    chk16("R3 compare value on reg", regv, 16'h0010);
    expect_ev(16'h0010, 1'b1, "R3 compare match");
    sweep(1, 16'h18);
    cv = 16'h0030; cw = 1'b1;
    step(1);
    cw = 1'b0;
    sweep(16'h19, 16'h40);
    chk16("R4 pending value not yet active", regv, 16'h0010);
    tbus = 16'h0000;
    step(2);
    chk16("R4 value active after bus zero", regv, 16'h0030);
    expect_ev(16'h0030, 1'b1, "R3 compare new value");
    sweep(1, 16'h38);
    step(2);

    // timer with overflow
    cfg(2'b00, 2'b01, 2'b00, 1'b0, 1'b0);
    tbus = 16'hFFFD;
    expect_ev(16'hFFFD, 1'b0, "R7 hold capture");
    pulse();
    cfg(2'b10, 2'b01, 2'b01, 1'b0, 1'b0);
    pulse();
    chk16("R5 timer step", regv, 16'hFFFE);
    pulse();
    chk16("R5 timer step to max", regv, 16'hFFFF);
    expect_ev(16'h0000, 1'b0, "R5 overflow");
    pulse();

    // one-shot
    cfg(2'b00, 2'b01, 2'b11, 1'b1, 1'b0);
    tbus = 16'h0AAA;
    expect_ev(16'h0AAA, 1'b0, "R9 first shot");
    pulse();
    tbus = 16'h0BBB;
    pulse();
    chk16("R9 locked reg", regv, 16'h0AAA);
    chk1("R9 locked pin", pin, exp_pin);
    chn = 1'b1;
    step(1);
    chn = 1'b0;
    step(1);
    chk1("R9 locked chain action", pin, exp_pin);
    cfg(2'b00, 2'b01, 2'b11, 1'b1, 1'b0);
    tbus = 16'h0CCC;
    expect_ev(16'h0CCC, 1'b0, "R9 rearmed");
    pulse();

    // chain forwarding and linked action
    cfg(2'b00, 2'b01, 2'b11, 1'b0, 1'b0);
    chn = 1'b1;
    @(negedge clk_i);
    chk1("R10 chain forwarded", chain_out, 1'b1);
    step(1);
    chn = 1'b0;
    exp_pin = ~exp_pin;
    @(negedge clk_i);
    chk1("R11 linked toggle", pin, exp_pin);
    step(2);

    // reset timer
    cfg(2'b11, 2'b00, 2'b01, 1'b0, 1'b0);
    evt = 1'b1;
    step(6);
    @(negedge clk_i);
    a = regv;
    @(negedge clk_i);
    chk16("R6 reset timer counts", regv, 16'(a + 16'd1));
    step(1);
    expect_ev(16'h0000, 1'b0, "R6 chain clear");
    chn = 1'b1;
    step(1);
    chn = 1'b0;
    step(3);
    evt = 1'b0;
    step(4);
    chk16("R8 all expected requests seen", 16'(sb_q.size()), 16'd0);

    // PWM chain: period 20, duties 5 and 12
    pw_cv[0] = 16'd19; pw_cv[2] = 16'd5; pw_cv[3] = 16'd12;
    pw_cw[0] = 1'b1; pw_cw[2] = 1'b1; pw_cw[3] = 1'b1;
    step(1);
    pw_cw[0] = 1'b0; pw_cw[2] = 1'b0; pw_cw[3] = 1'b0;
    step(2);
    pw_mode[0] = 2'b01; pw_act[0] = 2'b00; pw_link[0] = 1'b1;
    pw_mode[1] = 2'b11; pw_act[1] = 2'b00; pw_link[1] = 1'b1;
    pw_mode[2] = 2'b01; pw_act[2] = 2'b11; pw_link[2] = 1'b0;
    pw_mode[3] = 2'b01; pw_act[3] = 2'b11; pw_link[3] = 1'b0;
    pw_we = 1'b1;
    step(1);
    pw_we = 1'b0;
    pw_evt = 1'b1;
    step(50);
    npulse = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      if (pw_cho[1]) npulse++;
    end
    chk16("R12 period events in 60 cycles", 16'(npulse), 16'd3);
    count_high(2, 20, hi);
    chk16("R12 channel 2 high time", 16'(hi), 16'd14);
    count_high(3, 20, hi);
    chk16("R12 channel 3 high time", 16'(hi), 16'd7);

    // duty change mid-period takes effect only at the boundary
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (pw_reg[1] == 16'd5) break;
    end
    @(posedge clk_i);
    #1;
    pw_cv[2] = 16'd8; pw_cw[2] = 1'b1;
    step(1);
    pw_cw[2] = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (pw_reg[2] == 16'd8) break;
    end
    chk16("R4 update lands at period start", pw_reg[1], 16'd1);
    step(40);
    count_high(2, 20, hi);
    chk16("R12 channel 2 new high time", 16'(hi), 16'd11);

    report();
  end
endmodule